// File: doc/BRIEF.md
# Audio Port Interrupt Status Unit

This unit gathers the event and level indications of a serial audio port into one status word and raises a single interrupt line to the processor. Short event pulses from the serializer and FIFO logic (underrun, overrun, frame error, end of transfer, suspend and others) set sticky flags. Level indications such as receive data ready and transmit space available are shown live. An enable register selects which status bits may raise the interrupt.

Software uses three word registers on a plain 32-bit register bus. The enable register sits at byte offset 0x0 and the status register at 0x4. The flag-clear register at 0x8 is write-one-to-clear. A write completes on the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`, with no strobe. Event inputs are one-cycle pulses, and level inputs may change on any cycle. The interrupt output is registered, so it follows the masked status one cycle after the status register changes.

Top module: `audio_irq_status`

## Requirements
- R1: After reset the enable register, every status bit and the interrupt output are all zero.
- R2: Status bits 2:0 show the receive-ready, transmit-space and duplex-ready levels. They are sampled every cycle and appear in status one edge after the input. No write to any register clears them.
- R3: Status bit 12 shows transmit-complete, bits 14:13 the 2-bit receive packing level, and bit 15 the receive-word-not-empty level. All three are sampled live with one edge of latency. Status bits 31:16 read as zero.
- R4: A pulse on an event input sets its sticky status bit on the next edge, and the bit stays set until it is cleared. The mapping is: bit 3 end of transfer, bit 4 transfer filled, bit 5 underrun, bit 6 overrun, bit 7 CRC error, bit 8 frame error, bit 9 mode fault, bit 10 reload, bit 11 suspend.
- R5: Writing the clear register (0x8) clears each sticky bit among 3 to 11 whose data bit is 1. Data bits that are 0 leave their flag unchanged. The clear register always reads as zero.
- R6: If an event pulse and a clear write for the same flag fall in the same cycle, the flag ends up set.
- R7: In the enable register (0x0), bits 10:0 are read/write and bits 31:11 always read as zero.
- R8: The interrupt is high in a cycle exactly when, one edge earlier, status bits 10:0 ANDed with the enable register were nonzero. Suspend (bit 11) can never raise the interrupt.
- R9: Writes to the status register (0x4) or to an unmapped offset change nothing. Reads of an unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| lvl_rx_ready | input | 1 | Receive packet available level |
| lvl_tx_space | input | 1 | Transmit space available level |
| lvl_duplex | input | 1 | Duplex packet level |
| lvl_tx_done | input | 1 | Transmit complete level |
| lvl_rx_pack | input | 2 | Receive packing level |
| lvl_rx_word | input | 1 | Receive word not empty level |
| ev_eot | input | 1 | End of transfer pulse |
| ev_txfill | input | 1 | Transfer filled pulse |
| ev_underrun | input | 1 | Underrun pulse |
| ev_overrun | input | 1 | Overrun pulse |
| ev_crc | input | 1 | CRC error pulse |
| ev_frame | input | 1 | Frame error pulse |
| ev_modefault | input | 1 | Mode fault pulse |
| ev_reload | input | 1 | Reload pulse |
| ev_suspend | input | 1 | Suspend pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the cycle where an event pulse and a clear write for the same flag land together. A design that lets the clear win would silently drop an overrun. It writes all ones to the clear register while the live levels are high: a design that treats bits 2:0 as sticky would lose them, and one that decodes too wide a mask would clear them. It sets suspend with every enable bit written to one, which catches a mask that is one bit too wide. It also times the interrupt edge after a set, after a clear and after a mask change, so a combinational path or an extra register stage shows up as a wrong cycle.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_LIVE   = 3;
  localparam int NUM_STICKY = 9;
  localparam int STICKY_LSB = NUM_LIVE;
  localparam int STICKY_MSB = STICKY_LSB + NUM_STICKY - 1;
  localparam int EN_BITS    = 11;
  localparam int BIT_TXDONE = STICKY_MSB + 1;
  localparam int PACK_W     = 2;
  localparam int BIT_RXWORD = BIT_TXDONE + PACK_W + 1;
  localparam int USED_BITS  = BIT_RXWORD + 1;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_STATUS,
    SEL_CLEAR
  } reg_sel_e;
endpackage

// File: rtl/audio_irq_regdec.sv
module audio_irq_regdec
  import audio_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] OFF_EN   = 'h0,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h4,
  parameter logic [ADDR_W-1:0] OFF_CLR  = 'h8
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              we_enable,
  output logic              we_clear
);
  always_comb begin
    if (bus_addr == OFF_EN)        sel = SEL_ENABLE;
    else if (bus_addr == OFF_STAT) sel = SEL_STATUS;
    else if (bus_addr == OFF_CLR)  sel = SEL_CLEAR;
    else                           sel = SEL_NONE;
  end

  assign we_enable = bus_wr && (sel == SEL_ENABLE);
  assign we_clear  = bus_wr && (sel == SEL_CLEAR);
endmodule

// File: rtl/audio_irq_flags.sv
module audio_irq_flags #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr_vec[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_irq_mask.sv
module audio_irq_mask #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] enable,
  output logic         irq_q
);
  logic hit;
  assign hit = |(stat & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit;
  end
endmodule

// File: rtl/audio_irq_status.sv
module audio_irq_status
  import audio_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] OFF_EN   = 'h0,
  parameter logic [ADDR_W-1:0] OFF_STAT = 'h4,
  parameter logic [ADDR_W-1:0] OFF_CLR  = 'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              lvl_rx_ready,
  input  logic              lvl_tx_space,
  input  logic              lvl_duplex,
  input  logic              lvl_tx_done,
  input  logic [1:0]        lvl_rx_pack,
  input  logic              lvl_rx_word,
  input  logic              ev_eot,
  input  logic              ev_txfill,
  input  logic              ev_underrun,
  input  logic              ev_overrun,
  input  logic              ev_crc,
  input  logic              ev_frame,
  input  logic              ev_modefault,
  input  logic              ev_reload,
  input  logic              ev_suspend,
  output logic              irq
);
  reg_sel_e                sel;
  logic                    we_enable, we_clear;
  logic [EN_BITS-1:0]      en_q;
  logic [NUM_LIVE-1:0]     live_in, live_q;
  logic                    txdone_q, rxword_q;
  logic [PACK_W-1:0]       pack_q;
  logic [NUM_STICKY-1:0]   set_vec, clr_vec, sticky_q;
  logic [REG_W-1:0]        status_w;
  logic                    unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[REG_W-1:STICKY_MSB+1];

  audio_irq_regdec #(
    .ADDR_W(ADDR_W), .OFF_EN(OFF_EN), .OFF_STAT(OFF_STAT), .OFF_CLR(OFF_CLR)
  ) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .sel(sel),
    .we_enable(we_enable), .we_clear(we_clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (we_enable) en_q <= bus_wdata[EN_BITS-1:0];
  end

  assign live_in = {lvl_duplex, lvl_tx_space, lvl_rx_ready};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      txdone_q <= 1'b0;
      pack_q   <= '0;
      rxword_q <= 1'b0;
    end else begin
      live_q   <= live_in;
      txdone_q <= lvl_tx_done;
      pack_q   <= lvl_rx_pack;
      rxword_q <= lvl_rx_word;
    end
  end

  assign set_vec = {ev_suspend, ev_reload, ev_modefault, ev_frame, ev_crc,
                    ev_overrun, ev_underrun, ev_txfill, ev_eot};
  assign clr_vec = we_clear ? bus_wdata[STICKY_MSB:STICKY_LSB] : '0;

  audio_irq_flags #(.N(NUM_STICKY)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .flag_q(sticky_q)
  );

  assign status_w = {{(REG_W-USED_BITS){1'b0}}, rxword_q, pack_q, txdone_q,
                     sticky_q, live_q};

  audio_irq_mask #(.W(EN_BITS)) u_mask (
    .clk(clk), .rst_n(rst_n), .stat(status_w[EN_BITS-1:0]), .enable(en_q),
    .irq_q(irq)
  );

  always_comb begin
    unique case (sel)
      SEL_ENABLE: bus_rdata = {{(REG_W-EN_BITS){1'b0}}, en_q};
      SEL_STATUS: bus_rdata = status_w;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_irq_status_chk.sv
module audio_irq_status_chk
  import audio_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] OFF_EN  = 'h0,
  parameter logic [ADDR_W-1:0] OFF_CLR = 'h8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_STICKY-1:0] set_vec,
  input logic [NUM_STICKY-1:0] clr_vec,
  input logic [NUM_STICKY-1:0] sticky_q,
  input logic [NUM_LIVE-1:0]   live_in,
  input logic [NUM_LIVE-1:0]   live_q,
  input logic [EN_BITS-1:0]    en_q,
  input logic                  irq,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_rdata
);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((sticky_q & $past(set_vec)) == $past(set_vec)));

  assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((sticky_q & $past(clr_vec & ~set_vec)) == '0));

  assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sticky_q) & ~$past(clr_vec) & ~sticky_q) == '0));

  assert_live_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (live_q == $past(live_in)));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(en_q) != '0));

  assert_clear_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_CLR) |-> (bus_rdata == '0));

  assert_enable_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_EN) |-> (bus_rdata[31:EN_BITS] == '0));
endmodule

bind audio_irq_status audio_irq_status_chk #(
  .ADDR_W(ADDR_W), .OFF_EN(OFF_EN), .OFF_CLR(OFF_CLR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
  .sticky_q(sticky_q), .live_in(live_in), .live_q(live_q), .en_q(en_q),
  .irq(irq), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/audio_irq_status_tb_top.sv
module audio_irq_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_EN = 4'h0, A_ST = 4'h4, A_CLR = 4'h8, A_BAD = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  lvl = '0;
  logic        lvl_tx_done = 1'b0, lvl_rx_word = 1'b0;
  logic [1:0]  lvl_rx_pack = '0;
  logic [8:0]  ev = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl_rx_ready(lvl[0]), .lvl_tx_space(lvl[1]), .lvl_duplex(lvl[2]),
    .lvl_tx_done(lvl_tx_done), .lvl_rx_pack(lvl_rx_pack), .lvl_rx_word(lvl_rx_word),
    .ev_eot(ev[0]), .ev_txfill(ev[1]), .ev_underrun(ev[2]), .ev_overrun(ev[3]),
    .ev_crc(ev[4]), .ev_frame(ev[5]), .ev_modefault(ev[6]), .ev_reload(ev[7]),
    .ev_suspend(ev[8]), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [8:0] v);
    @(negedge clk);
    ev = v;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_EN, d);  chk("R1 enable", d, 32'h0);
    rd(A_ST, d);  chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    logic [31:0] exp = '0;
    for (int i = 0; i < 9; i++) begin
      pulse(9'(1 << i));
      @(negedge clk);
      exp |= 32'(1) << (i + 3);
      rd(A_ST, d); chk("R4 sticky accumulate", d, exp);
    end
    wr(A_CLR, 32'h0);
    rd(A_ST, d); chk("R5 zero write no effect", d, 32'h0000_0FF8);
    wr(A_CLR, 32'h0000_0FF8);
    rd(A_ST, d); chk("R5 clear all sticky", d, 32'h0);
  endtask

  task automatic t_clear_partial();
    logic [31:0] d;
    pulse(9'b000001100);
    wr(A_CLR, 32'h20);
    rd(A_ST, d); chk("R5 clear bit5 only", d, 32'h40);
    rd(A_CLR, d); chk("R5 clear reads zero", d, 32'h0);
    wr(A_CLR, 32'h40);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    pulse(9'b000000100);
    @(negedge clk);
    ev = 9'b000001000;
    bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h60;
    @(negedge clk);
    ev = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(A_ST, d); chk("R6 set beats clear", d, 32'h40);
    wr(A_CLR, 32'h40);
  endtask

  task automatic t_live();
    logic [31:0] d;
    @(negedge clk);
    lvl = 3'b101; lvl_tx_done = 1'b1; lvl_rx_pack = 2'b10; lvl_rx_word = 1'b1;
    @(negedge clk);
    rd(A_ST, d); chk("R2 R3 live levels", d, 32'h0000_D005);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R2 live not clearable", d, 32'h0000_D005);
    lvl = 3'b010; lvl_tx_done = 1'b0; lvl_rx_pack = 2'b01; lvl_rx_word = 1'b0;
    @(negedge clk);
    rd(A_ST, d); chk("R3 live change", d, 32'h0000_2002);
    lvl = '0; lvl_rx_pack = '0;
    @(negedge clk);
    rd(A_ST, d); chk("R2 live drop", d, 32'h0);
  endtask

  task automatic t_irq();
    wr(A_EN, 32'h20);
    pulse(9'b000000100);
    chk("R8 irq one edge after flag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    wr(A_CLR, 32'h20);
    chk("R8 irq lag after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);
    pulse(9'b000000100);
    @(negedge clk);
    wr(A_EN, 32'h0);
    chk("R8 irq lag after mask", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CLR, 32'h20);
  endtask

  task automatic t_suspend();
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R7 enable width", d, 32'h0000_07FF);
    pulse(9'b100000000);
    @(negedge clk); @(negedge clk);
    rd(A_ST, d); chk("R4 suspend flag", d, 32'h0000_0800);
    chk("R8 suspend no irq", {31'b0, irq}, 32'h0);
    wr(A_CLR, 32'h800);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(A_EN, 32'h0000_0155);
    pulse(9'b000010001);
    wr(A_ST, 32'h0);
    rd(A_ST, d); chk("R9 status write ignored", d, 32'h0000_0088);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R9 unmapped write status", d, 32'h0000_0088);
    rd(A_EN, d); chk("R9 unmapped write enable", d, 32'h0000_0155);
    rd(A_BAD, d); chk("R9 unmapped read zero", d, 32'h0);
    wr(A_CLR, 32'h88);
    wr(A_EN, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_clear_partial();
    t_collision();
    t_live();
    t_irq();
    t_suspend();
    t_readonly();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule